// File: doc/BRIEF.md
# Dual-Table Branch Condition Evaluator

This block decides whether a conditional branch is taken. It receives a condition code together with the carry, zero, sign and overflow flags and returns one bit that is high when the named condition holds for those flags. Two processor families use the same sixteen conditions but place them at different code points. A mode input selects which numbering applies. The conditions cover unsigned ordering, equality, sign, overflow and signed ordering. In each mode some code points are unassigned and always read as false.

The block is purely combinational. It has no clock, no reset and no state, so it can sit directly in a decode or execute stage. A thin top wraps a decoder and an evaluator. The decoder turns (mode, code) into a small strobe bundle: a valid bit, an invert bit and a predicate select. The evaluator forms the seven base predicates from the flags, selects one, applies the polarity and gates the result with the valid bit.

Top module: `br_cond_eval`

## Requirements
- R1: With `wideMode`=0, codes 0 to 7 give C, C&!Z, Z, S, !C, !(C&!Z), !Z and !S, in that order.
- R2: With `wideMode`=0, the codes give (S^O)|Z at 8, O at 9, !(S^O) at 10, !((S^O)|Z) at 12, !O at 13 and S^O at 14.
- R3: With `wideMode`=0, codes 11 and 15 give 0 for every flag combination.
- R4: With `wideMode`=1, codes 0 to 6 give !C, !(C&!Z), !Z, !S, !O, !((S^O)|Z) and !(S^O), in that order.
- R5: With `wideMode`=1, codes 8 to 14 give C, C&!Z, Z, S, O, (S^O)|Z and S^O, in that order.
- R6: With `wideMode`=1, codes 7 and 15 give 0 for every flag combination.
- R7: Only bits [3:0] of `condIn` select the condition. Any value in the upper bits leaves `condTrue` unchanged.
- R8: `condTrue` follows its inputs combinationally. A change of the flags or the code between clock edges shows at the output with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wideMode | input | 1 | 0 selects the 16-bit-address numbering, 1 selects the 24-bit-address numbering |
| condIn | input | CODE_IN_W (8) | Condition code; only bits [3:0] are used |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagO | input | 1 | Overflow flag |
| condTrue | output | 1 | High when the selected condition holds |

## Verification
Every code in both modes is applied against all sixteen flag combinations, and each result is compared with a value the bench derives from the predicate formulas.

- The sixteen flag patterns separate each predicate from every other. This exposes a code mapped to the wrong predicate or given the wrong polarity, and a signed test built from the wrong flags.
- Repeating the sweep with varied upper code bits shows that those bits cannot change the result.
- Changing flags and code between clock edges shows that the output needs no edge to follow them.

// File: rtl/br_cond_pkg.sv
package br_cond_pkg;
  localparam int SEL_CODE_W = 4;

  typedef enum logic [2:0] {
    PRED_C   = 3'd0,
    PRED_GTU = 3'd1,
    PRED_Z   = 3'd2,
    PRED_S   = 3'd3,
    PRED_O   = 3'd4,
    PRED_LE  = 3'd5,
    PRED_LT  = 3'd6,
    PRED_NONE = 3'd7
  } predSel_t;

  typedef struct packed {
    logic     valid;
    logic     invert;
    predSel_t sel;
  } condStrobe_t;
endpackage

// File: rtl/br_cond_ctrl.sv
module br_cond_ctrl
  import br_cond_pkg::*;
(
  input  logic                  wideMode,
  input  logic [SEL_CODE_W-1:0] code,
  output condStrobe_t           strobe
);
  condStrobe_t narrowStrobe;
  condStrobe_t wideStrobe;

  // 16-bit-address numbering: irregular placement, decoded per code
  always_comb begin
    narrowStrobe = '{valid: 1'b1, invert: 1'b0, sel: PRED_NONE};
    unique case (code)
      4'd0:  narrowStrobe.sel = PRED_C;
      4'd1:  narrowStrobe.sel = PRED_GTU;
      4'd2:  narrowStrobe.sel = PRED_Z;
      4'd3:  narrowStrobe.sel = PRED_S;
      4'd4:  begin narrowStrobe.sel = PRED_C;   narrowStrobe.invert = 1'b1; end
      4'd5:  begin narrowStrobe.sel = PRED_GTU; narrowStrobe.invert = 1'b1; end
      4'd6:  begin narrowStrobe.sel = PRED_Z;   narrowStrobe.invert = 1'b1; end
      4'd7:  begin narrowStrobe.sel = PRED_S;   narrowStrobe.invert = 1'b1; end
      4'd8:  narrowStrobe.sel = PRED_LE;
      4'd9:  narrowStrobe.sel = PRED_O;
      4'd10: begin narrowStrobe.sel = PRED_LT;  narrowStrobe.invert = 1'b1; end
      4'd12: begin narrowStrobe.sel = PRED_LE;  narrowStrobe.invert = 1'b1; end
      4'd13: begin narrowStrobe.sel = PRED_O;   narrowStrobe.invert = 1'b1; end
      4'd14: narrowStrobe.sel = PRED_LT;
      default: narrowStrobe.valid = 1'b0;
    endcase
  end

  // 24-bit-address numbering: top bit is polarity, low bits index predicate
  always_comb begin
    wideStrobe.sel    = predSel_t'(code[2:0]);
    wideStrobe.invert = ~code[3];
    wideStrobe.valid  = (code[2:0] != 3'd7);
  end

  assign strobe = wideMode ? wideStrobe : narrowStrobe;
endmodule

// File: rtl/br_cond_dp.sv
module br_cond_dp
  import br_cond_pkg::*;
(
  input  logic        flagC,
  input  logic        flagZ,
  input  logic        flagS,
  input  logic        flagO,
  input  condStrobe_t strobe,
  output logic        condTrue
);
  logic [7:0] predVec;
  logic       signedLess;
  logic       picked;

  assign signedLess = flagS ^ flagO;

  always_comb begin
    predVec           = '0;
    predVec[PRED_C]   = flagC;
    predVec[PRED_GTU] = flagC & ~flagZ;
    predVec[PRED_Z]   = flagZ;
    predVec[PRED_S]   = flagS;
    predVec[PRED_O]   = flagO;
    predVec[PRED_LE]  = signedLess | flagZ;
    predVec[PRED_LT]  = signedLess;
  end

  assign picked   = predVec[strobe.sel];
  assign condTrue = strobe.valid & (picked ^ strobe.invert);
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_cond_pkg::*;
#(
  parameter int CODE_IN_W = 8
) (
  input  logic                 wideMode,
  input  logic [CODE_IN_W-1:0] condIn,
  input  logic                 flagC,
  input  logic                 flagZ,
  input  logic                 flagS,
  input  logic                 flagO,
  output logic                 condTrue
);
  condStrobe_t strobe;
  logic [SEL_CODE_W-1:0] codeLow;

  assign codeLow = condIn[SEL_CODE_W-1:0];

  generate
    if (CODE_IN_W > SEL_CODE_W) begin : g_hiBits
      logic unusedHi;
      assign unusedHi = ^condIn[CODE_IN_W-1:SEL_CODE_W];
    end
  endgenerate

  br_cond_ctrl u_ctrl (
    .wideMode(wideMode),
    .code    (codeLow),
    .strobe  (strobe)
  );

  br_cond_dp u_dp (
    .flagC   (flagC),
    .flagZ   (flagZ),
    .flagS   (flagS),
    .flagO   (flagO),
    .strobe  (strobe),
    .condTrue(condTrue)
  );
endmodule

// File: rtl/br_cond_eval_chk.sv
module br_cond_eval_chk #(
  parameter int CODE_IN_W = 8
) (
  input logic                 wideMode,
  input logic [CODE_IN_W-1:0] condIn,
  input logic                 flagC,
  input logic                 flagZ,
  input logic                 flagS,
  input logic                 flagO,
  input logic                 condTrue
);
  logic [3:0] lowCode;
  logic       known;

  assign lowCode = condIn[3:0];
  assign known   = !$isunknown({wideMode, lowCode, flagC, flagZ, flagS, flagO, condTrue});

  always_comb begin
    if (known) begin
      if (!wideMode && lowCode == 4'd0)
        AST_NARROW_CARRY: assert (condTrue == flagC);                 // R1
      if (!wideMode && lowCode == 4'd9)
        AST_NARROW_OVF: assert (condTrue == flagO);                   // R2
      if (!wideMode && (lowCode == 4'd11 || lowCode == 4'd15))
        AST_NARROW_UNASSIGNED: assert (!condTrue);                    // R3
      if (wideMode && lowCode == 4'd2)
        AST_WIDE_NOT_ZERO: assert (condTrue == !flagZ);               // R4
      if (wideMode && lowCode == 4'd14)
        AST_WIDE_SIGNED_LESS: assert (condTrue == (flagS ^ flagO));   // R5
      if (wideMode && (lowCode == 4'd7 || lowCode == 4'd15))
        AST_WIDE_UNASSIGNED: assert (!condTrue);                      // R6
    end
  end
endmodule

bind br_cond_eval br_cond_eval_chk #(.CODE_IN_W(CODE_IN_W)) u_chk (
  .wideMode(wideMode),
  .condIn  (condIn),
  .flagC   (flagC),
  .flagZ   (flagZ),
  .flagS   (flagS),
  .flagO   (flagO),
  .condTrue(condTrue)
);

// File: tb/br_cond_eval_bench.sv
`timescale 1ns/1ps
module br_cond_eval_bench;
  localparam int CODE_IN_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                 wideMode = 1'b0;
  logic [CODE_IN_W-1:0] condIn = '0;
  logic                 flagC = 1'b0, flagZ = 1'b0, flagS = 1'b0, flagO = 1'b0;
  logic                 condTrue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  br_cond_eval #(.CODE_IN_W(CODE_IN_W)) u_br_cond_eval (
    .wideMode(wideMode), .condIn(condIn),
    .flagC(flagC), .flagZ(flagZ), .flagS(flagS), .flagO(flagO),
    .condTrue(condTrue)
  );

  function automatic bit expectOf(input bit wide, input int code, input int f);
    bit c, z, s, o, gtu, lt, le;
    c = f[0]; z = f[1]; s = f[2]; o = f[3];
    gtu = c & !z; lt = s ^ o; le = lt | z;
    if (!wide) begin
      case (code)
        0: return c;    1: return gtu;   2: return z;    3: return s;
        4: return !c;   5: return !gtu;  6: return !z;   7: return !s;
        8: return le;   9: return o;     10: return !lt;
        12: return !le; 13: return !o;   14: return lt;
        default: return 1'b0;
      endcase
    end else begin
      case (code)
        0: return !c;   1: return !gtu;  2: return !z;   3: return !s;
        4: return !o;   5: return !le;   6: return !lt;
        8: return c;    9: return gtu;   10: return z;   11: return s;
        12: return o;   13: return le;   14: return lt;
        default: return 1'b0;
      endcase
    end
  endfunction

  function automatic string reqOf(input bit wide, input int code);
    if (!wide) begin
      if (code == 11 || code == 15) return "R3";
      return (code < 8) ? "R1" : "R2";
    end
    if (code == 7 || code == 15) return "R6";
    return (code < 8) ? "R4" : "R5";
  endfunction

  task automatic check(input string req, input bit exp, input string what);
    checks++;
    if (condTrue !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, condTrue, exp);
    end
  endtask

  task automatic apply(input bit wide, input int code, input int f);
    @(negedge clk);
    wideMode = wide;
    condIn   = CODE_IN_W'(code);
    {flagO, flagS, flagZ, flagC} = 4'(f);
    #2;
  endtask

  initial begin
    // Exhaustive sweep of both tables (R1..R6)
    for (int m = 0; m < 2; m++)
      for (int cd = 0; cd < 16; cd++)
        for (int f = 0; f < 16; f++) begin
          apply(m[0], cd, f);
          check(reqOf(m[0], cd), expectOf(m[0], cd, f),
                $sformatf("mode %0d code %0d flags %h", m, cd, f));
        end

    // R7: upper code bits ignored
    for (int m = 0; m < 2; m++)
      for (int cd = 0; cd < 16; cd++)
        for (int f = 0; f < 16; f++) begin
          apply(m[0], ((cd * 7 + f * 3 + 1) % 16) * 16 + cd, f);
          check("R7", expectOf(m[0], cd, f),
                $sformatf("upper bits mode %0d code %0d flags %h", m, cd, f));
        end

    // R8: output follows inputs between clock edges
    @(posedge clk);
    #3;
    wideMode = 1'b1; condIn = 8'd10; {flagO, flagS, flagZ, flagC} = 4'b0000;
    #1; check("R8", 1'b0, "wide Z with Z clear, mid-cycle");
    flagZ = 1'b1;
    #1; check("R8", 1'b1, "wide Z after Z set, same cycle");
    condIn = 8'd2;
    #1; check("R8", 1'b0, "wide !Z after code change, same cycle");
    wideMode = 1'b0;
    #1; check("R8", 1'b1, "narrow Z after mode change, same cycle");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule